// File: doc/BRIEF.md
# Byte-Serial Instruction Fetch Engine

This block fetches one 18-bit instruction word for a small 8-bit controller core from program memory that sits outside the core, on a shared bus with an 8-bit data path. When the core presents a fetch request with a program counter value, the engine runs three single-byte read transfers in turn. Their order is fixed and ascending. It packs the returned bytes into one opcode and announces the result with a one-cycle valid pulse. The opcode stays on its output until the next fetch completes.

The bus side uses plain single transfers only. The engine never writes, never bursts and never locks the bus. The error and retry inputs are present on the port list but have no effect. The size of the program space is a parameter: 256, 512, 1024, 2048 or 4096 instruction words. The program counter is log2 of that size wide.

The control is a five-state machine:
- `ST_IDLE` waits for a request and goes to `ST_ISSUE` when one is accepted.
- `ST_ISSUE` raises cycle and strobe for one clock, then goes to `ST_WAIT`.
- `ST_WAIT` holds cycle with strobe low. When acknowledge arrives it latches the data byte and goes to `ST_CAPTURE`.
- `ST_CAPTURE` writes the latched byte into its opcode slot, then goes to `ST_ADVANCE`.
- `ST_ADVANCE` returns to `ST_ISSUE` for the next byte. After the third byte it goes back to `ST_IDLE` and publishes the opcode.

Top module: `bfe_fetch_top`

## Requirements
- R1: A synchronous reset leaves cycle, strobe and opcode-valid low. It also leaves the engine idle, so no bus transfer starts until a new request is given. This holds even when reset arrives in the middle of a fetch.
- R2: Cycle goes high with the strobe of each byte transfer. It stays high until acknowledge is seen, and it is low in the clock after the acknowledge.
- R3: Strobe is high for exactly one clock per byte transfer: the first clock of the transfer.
- R4: The address of byte k (k = 0, 1, 2) of instruction n is 4*n + k, zero-extended to 32 bits. It stays stable while a transfer is waiting for acknowledge.
- R5: The opcode is assembled as follows. Byte 0 gives bits [7:0] and byte 1 gives bits [15:8]. Bits [1:0] of byte 2 give bits [17:16], and bits [7:2] of byte 2 are discarded.
- R6: Each fetch performs exactly three byte transfers, at ascending addresses.
- R7: Opcode-valid is a single-clock pulse. After the pulse, the opcode output keeps its value.
- R8: The request is sampled at a clock edge. If acknowledge arrives in the clock right after strobe, opcode-valid rises 12 clock edges after that edge. Each extra clock of acknowledge delay per byte adds one clock per byte, for a total of 12 + 3*D.
- R9: A request given while a fetch is under way is ignored. The running fetch completes with its own address, and no further transfer follows.
- R10: The fixed outputs hold these values: cycle-type 2'b00, burst-type 3'b000, write-enable 0, byte-select 4'b1111, write-data 8'h00, lock 0. The error and retry inputs have no effect.
- R11: Read data is taken only in the clock where acknowledge is high. Values on the data input at other times do not reach the opcode.
- R12: The parameter DEPTH sets the program space. The program counter input is $clog2(DEPTH) bits wide, and the whole range, including the top value, maps to R4 addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fetch_req_i | input | 1 | Fetch request, taken only while idle |
| fetch_pc_i | input | PC_W | Program counter of the instruction to fetch |
| opcode_o | output | 18 | Assembled opcode |
| opcode_vld_o | output | 1 | One-clock pulse when opcode_o is new |
| bus_cyc_o | output | 1 | Bus cycle active |
| bus_stb_o | output | 1 | Bus strobe, first clock of each transfer |
| bus_cti_o | output | 2 | Cycle type, fixed 2'b00 |
| bus_bte_o | output | 3 | Burst type, fixed 3'b000 |
| bus_adr_o | output | 32 | Byte address |
| bus_we_o | output | 1 | Write enable, fixed 0 |
| bus_sel_o | output | 4 | Byte select, fixed 4'b1111 |
| bus_dat_o | output | 8 | Write data, fixed 8'h00 |
| bus_lock_o | output | 1 | Bus lock, fixed 0 |
| bus_ack_i | input | 1 | Transfer acknowledge |
| bus_err_i | input | 1 | Error input, ignored |
| bus_rty_i | input | 1 | Retry input, ignored |
| bus_dat_i | input | 8 | Read data byte |

## Verification
Faults in the state machine show up at the bus within one byte transfer:
- A stuck or skipped state shows as a strobe lasting two clocks or a missing strobe.
- A cycle signal that does not fall after acknowledge is another sign.
- A wrong count of transfers shows in the number of strobes before the valid pulse.

A wrong byte index or an unlatched program counter shows at the next strobe as an address other than 4*n + k. A slot written at the wrong time shows at the valid pulse as a misplaced or garbage byte in the opcode, because the data bus carries non-acknowledged junk between transfers. A miscounted wait path shifts the valid pulse away from 12 + 3*D clocks.

// File: rtl/bfe_pkg.sv
package bfe_pkg;

    localparam int NUM_BYTES = 3;
    localparam int OPC_W     = 18;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = $clog2(NUM_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ISSUE   = 3'd1,
        ST_WAIT    = 3'd2,
        ST_CAPTURE = 3'd3,
        ST_ADVANCE = 3'd4
    } bfe_state_e;

endpackage

// File: rtl/bfe_ctrl_fsm.sv
module bfe_ctrl_fsm
    import bfe_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_i,
    input  logic ack_i,
    input  logic last_byte_i,
    output logic cyc_o,
    output logic stb_o,
    output logic accept_o,
    output logic hold_en_o,
    output logic slot_wr_o,
    output logic byte_adv_o,
    output logic done_o
);

    bfe_state_e state_q, state_d;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = req_i ? ST_ISSUE : ST_IDLE;
            ST_ISSUE:   state_d = ST_WAIT;
            ST_WAIT:    state_d = ack_i ? ST_CAPTURE : ST_WAIT;
            ST_CAPTURE: state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = last_byte_i ? ST_IDLE : ST_ISSUE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // outputs
    always_comb begin
        cyc_o      = 1'b0;
        stb_o      = 1'b0;
        accept_o   = 1'b0;
        hold_en_o  = 1'b0;
        slot_wr_o  = 1'b0;
        byte_adv_o = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:    accept_o = req_i;
            ST_ISSUE: begin
                cyc_o = 1'b1;
                stb_o = 1'b1;
            end
            ST_WAIT: begin
                cyc_o     = 1'b1;
                hold_en_o = ack_i;
            end
            ST_CAPTURE: slot_wr_o = 1'b1;
            ST_ADVANCE: begin
                byte_adv_o = !last_byte_i;
                done_o     = last_byte_i;
            end
            default: ;
        endcase
    end

    AST_STB_FIRST_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
        stb_o |=> !stb_o); // R3
    AST_CYC_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_o && !ack_i) |=> cyc_o); // R2
    AST_CYC_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc_o && !stb_o && ack_i) |=> !cyc_o); // R2

endmodule

// File: rtl/bfe_addr_gen.sv
module bfe_addr_gen
    import bfe_pkg::*;
#(
    parameter int PC_W  = 8,
    parameter int ADR_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             accept_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             byte_adv_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o,
    output logic [ADR_W-1:0] adr_o
);

    localparam int WORD_SHIFT = 2;

    logic [PC_W-1:0]  pc_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pc_q  <= '0;
            idx_q <= '0;
        end else if (accept_i) begin
            pc_q  <= pc_i;
            idx_q <= '0;
        end else if (byte_adv_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == IDX_W'(NUM_BYTES - 1));
    assign adr_o  = (ADR_W'(pc_q) << WORD_SHIFT) + ADR_W'(idx_q);

endmodule

// File: rtl/bfe_opcode_packer.sv
module bfe_opcode_packer
    import bfe_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              hold_en_i,
    input  logic [BYTE_W-1:0] dat_i,
    input  logic              slot_wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              done_i,
    output logic [OPC_W-1:0]  opcode_o,
    output logic              valid_o
);

    logic [BYTE_W-1:0] hold_q;
    logic [OPC_W-1:0]  asm_w;
    logic [OPC_W-1:0]  opc_q;
    logic              vld_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)          hold_q <= '0;
        else if (hold_en_i) hold_q <= dat_i;
    end

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_slot
        localparam int LO = k * BYTE_W;
        localparam int W  = ((OPC_W - LO) < BYTE_W) ? (OPC_W - LO) : BYTE_W;
        logic [W-1:0] part_q;
        always_ff @(posedge clk_i) begin
            if (rst_i)
                part_q <= '0;
            else if (slot_wr_i && (idx_i == IDX_W'(k)))
                part_q <= hold_q[W-1:0];
        end
        assign asm_w[LO +: W] = part_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            opc_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= done_i;
            if (done_i) opc_q <= asm_w;
        end
    end

    assign opcode_o = opc_q;
    assign valid_o  = vld_q;

    AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o); // R7

endmodule

// File: rtl/bfe_fetch_top.sv
module bfe_fetch_top
    import bfe_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int PC_W = $clog2(DEPTH),
    localparam int ADR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              fetch_req_i,
    input  logic [PC_W-1:0]   fetch_pc_i,
    output logic [OPC_W-1:0]  opcode_o,
    output logic              opcode_vld_o,
    output logic              bus_cyc_o,
    output logic              bus_stb_o,
    output logic [1:0]        bus_cti_o,
    output logic [2:0]        bus_bte_o,
    output logic [ADR_W-1:0]  bus_adr_o,
    output logic              bus_we_o,
    output logic [3:0]        bus_sel_o,
    output logic [BYTE_W-1:0] bus_dat_o,
    output logic              bus_lock_o,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    input  logic              bus_rty_i,
    input  logic [BYTE_W-1:0] bus_dat_i
);

    logic             accept, hold_en, slot_wr, byte_adv, done, last_byte;
    logic [IDX_W-1:0] idx;

    bfe_ctrl_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .req_i       (fetch_req_i),
        .ack_i       (bus_ack_i),
        .last_byte_i (last_byte),
        .cyc_o       (bus_cyc_o),
        .stb_o       (bus_stb_o),
        .accept_o    (accept),
        .hold_en_o   (hold_en),
        .slot_wr_o   (slot_wr),
        .byte_adv_o  (byte_adv),
        .done_o      (done)
    );

    bfe_addr_gen #(.PC_W(PC_W), .ADR_W(ADR_W)) u_adr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .accept_i   (accept),
        .pc_i       (fetch_pc_i),
        .byte_adv_i (byte_adv),
        .idx_o      (idx),
        .last_o     (last_byte),
        .adr_o      (bus_adr_o)
    );

    bfe_opcode_packer u_pack (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .hold_en_i (hold_en),
        .dat_i     (bus_dat_i),
        .slot_wr_i (slot_wr),
        .idx_i     (idx),
        .done_i    (done),
        .opcode_o  (opcode_o),
        .valid_o   (opcode_vld_o)
    );

    // fixed single-read signalling
    assign bus_cti_o  = 2'b00;
    assign bus_bte_o  = 3'b000;
    assign bus_we_o   = 1'b0;
    assign bus_sel_o  = 4'b1111;
    assign bus_dat_o  = '0;
    assign bus_lock_o = 1'b0;

    logic unused_bus_in;
    assign unused_bus_in = bus_err_i ^ bus_rty_i;

    AST_ADR_STEADY: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_cyc_o && !bus_ack_i) |=> $stable(bus_adr_o)); // R4
    AST_NO_VALID_MIDBUS: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_cyc_o |-> !opcode_vld_o); // R6

endmodule

// File: tb/bfe_fetch_top_tb_top.sv
`timescale 1ns/1ps
module bfe_fetch_top_tb_top;

    localparam int DEPTH = 256;
    localparam int PC_W  = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [PC_W-1:0] pc = '0;
    logic [17:0] opcode;
    logic        vld, cyc, stb, we, lock, ack, err, rty;
    logic [1:0]  cti;
    logic [2:0]  bte;
    logic [31:0] adr;
    logic [3:0]  sel;
    logic [7:0]  dat_o, dat_i;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    bfe_fetch_top #(.DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_i(rst), .fetch_req_i(req), .fetch_pc_i(pc),
        .opcode_o(opcode), .opcode_vld_o(vld),
        .bus_cyc_o(cyc), .bus_stb_o(stb), .bus_cti_o(cti), .bus_bte_o(bte),
        .bus_adr_o(adr), .bus_we_o(we), .bus_sel_o(sel), .bus_dat_o(dat_o),
        .bus_lock_o(lock), .bus_ack_i(ack), .bus_err_i(err), .bus_rty_i(rty),
        .bus_dat_i(dat_i)
    );

    function automatic logic [7:0] memb(input logic [31:0] a);
        return 8'((a * 32'd29) ^ (a >> 2) ^ 32'hA5);
    endfunction

    function automatic logic [17:0] exp_opc(input int n);
        logic [31:0] b;
        b = 32'(n) * 4;
        return {memb(b + 2)[1:0], memb(b + 1), memb(b)};
    endfunction

    task automatic chk(input logic ok, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    // behavioural slave with configurable acknowledge delay
    int          ack_dly = 0;
    int          cnt_s;
    logic        pend;
    logic [31:0] lat_adr;
    logic [7:0]  junk = 8'h00;

    always @(posedge clk) begin
        junk <= junk + 8'h3B;
        err  <= junk[0];
        rty  <= junk[1];
        if (rst) begin
            ack  <= 1'b0;
            pend <= 1'b0;
            dat_i <= 8'h00;
        end else begin
            ack   <= 1'b0;
            dat_i <= junk ^ 8'hC3;
            if (pend) begin
                if (cnt_s == 0) begin
                    ack <= 1'b1; dat_i <= memb(lat_adr); pend <= 1'b0;
                end else cnt_s <= cnt_s - 1;
            end
            if (stb) begin
                lat_adr <= adr;
                if (ack_dly == 0) begin
                    ack <= 1'b1; dat_i <= memb(adr);
                end else begin
                    pend <= 1'b1; cnt_s <= ack_dly - 1;
                end
            end
        end
    end

    // bus monitor
    int cur_pc = 0;
    int kk = 0;
    logic stb_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && stb) begin
            chk(adr == 32'(cur_pc) * 4 + 32'(kk), "R4/R6/R12 byte address",
                adr, 32'(cur_pc) * 4 + 32'(kk));
            chk(cyc, "R2 cycle high with strobe", cyc, 1);
            chk(!stb_prev, "R3 strobe only first clock", stb_prev, 0);
            chk({cti, bte, we, sel, dat_o, lock} == {2'b00, 3'b000, 1'b0, 4'hF, 8'h00, 1'b0},
                "R10 fixed outputs", {cti, bte, we, sel, dat_o, lock},
                {2'b00, 3'b000, 1'b0, 4'hF, 8'h00, 1'b0});
            kk++;
        end
        stb_prev = stb;
    end

    task automatic fetch(input int n, input int d, input bit intrude);
        int  cnt;
        bit  done;
        @(negedge clk);
        ack_dly = d; cur_pc = n; kk = 0;
        req = 1'b1; pc = PC_W'(n);
        @(posedge clk);
        cnt = 0; done = 0;
        while (!done && cnt < 400) begin
            @(negedge clk);
            cnt++;
            req = intrude && (cnt == 5);
            if (req) pc = PC_W'(n ^ 8'h5A);
            if (vld) done = 1;
        end
        chk(done, "R8 valid reached", done, 1);
        chk(opcode == exp_opc(n), "R5/R11 opcode", opcode, exp_opc(n));
        chk(cnt - 1 == 12 + 3 * d, "R8 latency", cnt - 1, 12 + 3 * d);
        chk(kk == 3, "R6 three transfers", kk, 3);
        @(negedge clk);
        chk(!vld, "R7 valid single pulse", vld, 0);
        chk(opcode == exp_opc(n), "R7 opcode held", opcode, exp_opc(n));
        if (intrude) begin
            repeat (20) @(negedge clk);
            chk(kk == 3 && !cyc, "R9 busy request ignored", kk, 3);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!cyc && !stb && !vld, "R1 reset outputs low", {cyc, stb, vld}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(!cyc && kk == 0, "R1 idle after reset", cyc, 0);

        // full sweep of program space, acknowledge delay 0..3
        for (int n = 0; n < DEPTH; n++) fetch(n, n % 4, 1'b0);

        // top of space with long delay
        fetch(DEPTH - 1, 7, 1'b0);

        // requests while busy
        fetch(17, 0, 1'b1);
        fetch(200, 2, 1'b1);

        // reset in mid-fetch
        @(negedge clk);
        ack_dly = 1; cur_pc = 33; kk = 0; req = 1'b1; pc = PC_W'(33);
        @(negedge clk);
        req = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!cyc && !stb && !vld, "R1 reset mid-fetch", {cyc, stb, vld}, 0);
        rst = 1'b0;
        kk = 0;
        repeat (10) @(negedge clk);
        chk(!cyc && kk == 0, "R1 no transfer after reset", kk, 0);
        fetch(33, 0, 1'b0);
        fetch(34, 5, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule